// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block sits next to a UART transmitter and produces the driver-enable level for a half-duplex RS-485 transceiver. It watches the transmitter's activity: writes into the transmit FIFO, the FIFO-empty flag, the shift-register-idle flag and a one-cycle pulse that marks the end of each stop bit. From these it decides when the line belongs to the transmitter and when it is handed back to the receiver. The hand-back waits one full bit period after the last stop bit. That period is measured as sixteen ticks of the 16x baud enable.

The block also produces the transmit-empty interrupt request. In automatic mode the request is held back until the shift register has drained as well. With automatic mode off, the request follows the FIFO-empty flag alone, and the direction pin simply copies a manual RTS bit. A polarity bit selects which level means "transmit" in automatic mode.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: In automatic mode, an end-of-stop-bit pulse that arrives in the transmit state while the FIFO is empty starts a hold-off. The pin keeps its transmit level until the 16th baud tick sampled on a later clock edge. It shows the receive level from that edge on.
- R2: In automatic mode, a FIFO write puts the pin at its transmit level from the next clock edge, whatever state the block was in.
- R3: An end-of-stop-bit pulse that arrives while the FIFO is not empty leaves the pin at its transmit level, and no hold-off starts.
- R4: A FIFO write during the hold-off cancels it and keeps the transmit level. This holds even in the same cycle as the 16th tick. A later hold-off counts a fresh 16 ticks.
- R5: In automatic mode the transmit level equals the polarity bit and the receive level is its inverse. With the polarity bit at 0, transmit is low and receive is high.
- R6: In automatic mode the registered interrupt request is, one edge later, the AND of FIFO-empty and shift-idle.
- R7: With automatic mode off, the registered interrupt request is, one edge later, the FIFO-empty flag alone.
- R8: With automatic mode off, the pin equals the manual RTS input. The internal state returns to receive, so re-enabling automatic mode starts in the receive state.
- R9: After synchronous reset the state is receive (the pin is high with the polarity bit at 0 in automatic mode), the hold-off count is clear and the interrupt request is 0.
- R10: In the receive state, end-of-stop-bit pulses and baud ticks leave the pin at its receive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic direction mode enable |
| dir_inv | input | 1 | Polarity of the direction pin in automatic mode |
| mcr_rts | input | 1 | Manual RTS level used when automatic mode is off |
| fifo_wr | input | 1 | Byte written into the transmit FIFO this cycle |
| fifo_empty | input | 1 | Transmit FIFO holds no bytes |
| shift_idle | input | 1 | Transmit shift register is empty |
| stop_done | input | 1 | One-cycle pulse at the end of a stop bit |
| tick16 | input | 1 | 16x baud clock enable |
| dir_out | output | 1 | Direction (RTS) pin level |
| thr_irq | output | 1 | Transmit-empty interrupt request |

## Verification
A FIFO write and the 16th hold-off tick can land on the same clock edge, and the write must win so that the line stays with the transmitter. The bench brings the block into hold-off, issues fifteen ticks, then raises the last tick and a FIFO write together. It expects the transmit level after that edge and a full fresh 16-tick count on the next hold-off. An end-of-stop-bit pulse that coincides with a tick is covered too: that tick must not count toward the bit period. A behavioural model in the bench judges every cycle of both cases.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        DIR_RX   = 2'd0,
        DIR_TX   = 2'd1,
        DIR_HOLD = 2'd2
    } dir_state_e;

    typedef struct packed {
        logic fifo_wr;
        logic fifo_empty;
        logic stop_done;
    } tx_evt_t;

    function automatic logic drive_level(input logic transmit, input logic inv);
        return transmit ? inv : ~inv;
    endfunction

endpackage

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign done = run & tick & (cnt == LAST);

    // R4
    timer_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run)) |-> (cnt == '0));

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       auto_en,
    input  tx_evt_t    evt,
    input  logic       timer_done,
    output dir_state_e st,
    output logic       hold_run
);
    dir_state_e st_nx;

    always_comb begin
        st_nx = st;
        if (!auto_en) begin
            st_nx = DIR_RX;
        end else if (evt.fifo_wr) begin
            st_nx = DIR_TX;
        end else begin
            unique case (st)
                DIR_TX:   if (evt.stop_done && evt.fifo_empty) st_nx = DIR_HOLD;
                DIR_HOLD: if (timer_done) st_nx = DIR_RX;
                default:  st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DIR_RX;
        else     st <= st_nx;
    end

    assign hold_run = (st == DIR_HOLD) && auto_en && !evt.fifo_wr;

    // R2
    wr_to_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && evt.fifo_wr) |=> (st == DIR_TX));
    // R1
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (st == DIR_HOLD && auto_en && !evt.fifo_wr && !timer_done) |=> (st == DIR_HOLD));
    // R8
    legacy_rx_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (st == DIR_RX));
    // R9
    reset_rx_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st == DIR_RX));
    // R10
    rx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st == DIR_RX && !evt.fifo_wr) |=> (st == DIR_RX));

endmodule

// File: rtl/rs485_txirq_gen.sv
module rs485_txirq_gen (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic fifo_empty,
    input  logic shift_idle,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= fifo_empty & (shift_idle | ~auto_en);
    end

    // R6
    auto_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !shift_idle) |=> !irq);
    // R7
    legacy_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && fifo_empty) |=> irq);

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_en,
    input  logic dir_inv,
    input  logic mcr_rts,
    input  logic fifo_wr,
    input  logic fifo_empty,
    input  logic shift_idle,
    input  logic stop_done,
    input  logic tick16,
    output logic dir_out,
    output logic thr_irq
);
    tx_evt_t    evt;
    dir_state_e st;
    logic       hold_run;
    logic       timer_done;

    assign evt = '{fifo_wr: fifo_wr, fifo_empty: fifo_empty, stop_done: stop_done};

    rs485_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (hold_run),
        .tick (tick16),
        .done (timer_done)
    );

    rs485_dir_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .evt        (evt),
        .timer_done (timer_done),
        .st         (st),
        .hold_run   (hold_run)
    );

    rs485_txirq_gen u_irq (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .fifo_empty (fifo_empty),
        .shift_idle (shift_idle),
        .irq        (thr_irq)
    );

    assign dir_out = auto_en ? drive_level(st != DIR_RX, dir_inv) : mcr_rts;

    // R5
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_en && $past(auto_en) && $past(fifo_wr)) |-> (dir_out == dir_inv));

endmodule

// File: tb/rs485_dir_ctrl_test.sv
module rs485_dir_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_en = 1'b0, dir_inv = 1'b0, mcr_rts = 1'b0;
    logic fifo_wr = 1'b0, fifo_empty = 1'b1, shift_idle = 1'b1;
    logic stop_done = 1'b0, tick16 = 1'b0;
    logic dir_out, thr_irq;

    int checks = 0, fails = 0;
    bit finished = 0;
    string tag = "R9";

    // behavioural reference state
    bit m_tx = 0, m_hold = 0, m_irq = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    rs485_dir_ctrl uut (
        .clk(clk), .rst(rst), .auto_en(auto_en), .dir_inv(dir_inv), .mcr_rts(mcr_rts),
        .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .shift_idle(shift_idle),
        .stop_done(stop_done), .tick16(tick16), .dir_out(dir_out), .thr_irq(thr_irq)
    );

    task automatic chk(input string t, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", t, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_dir();
        if (!auto_en) return mcr_rts;
        return m_tx ? dir_inv : ~dir_inv;
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_tx = 0; m_hold = 0; m_cnt = 0; m_irq = 0;
        end else begin
            m_irq = auto_en ? (fifo_empty && shift_idle) : fifo_empty;
            if (!auto_en) begin
                m_tx = 0; m_hold = 0; m_cnt = 0;
            end else if (fifo_wr) begin
                m_tx = 1; m_hold = 0; m_cnt = 0;
            end else if (m_tx && !m_hold && stop_done && fifo_empty) begin
                m_hold = 1; m_cnt = 0;
            end else if (m_hold && tick16) begin
                if (m_cnt == 15) begin m_tx = 0; m_hold = 0; m_cnt = 0; end
                else m_cnt++;
            end
        end
        #2;
        chk(tag, dir_out, exp_dir(), "dir_out");
        chk(tag, thr_irq, m_irq, "thr_irq");
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_byte();
        fifo_wr = 1; step(); fifo_wr = 0;
    endtask

    task automatic stop_pulse();
        stop_done = 1; step(); stop_done = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick16 = 1; step(); tick16 = 0;
            cycles(gap - 1);
        end
    endtask

    initial begin
        // R9 reset state
        tag = "R9";
        auto_en = 1;
        cycles(3);
        rst = 0;
        #1;
        chk("R9", dir_out, 1'b1, "reset dir");
        chk("R9", thr_irq, 1'b0, "reset irq");
        cycles(2);

        // R10 receive ignores stop pulses and ticks
        tag = "R10";
        stop_pulse(); ticks(20, 2);
        chk("R10", dir_out, 1'b1, "rx stays");

        // R2 write turns on transmit
        tag = "R2";
        fifo_empty = 0; shift_idle = 0;
        write_byte();
        chk("R2", dir_out, 1'b0, "tx after write");

        // R3 back-to-back character
        tag = "R3";
        stop_pulse(); cycles(4); ticks(20, 2);
        chk("R3", dir_out, 1'b0, "stay tx");

        // R6 interrupt held while shifting
        tag = "R6";
        fifo_empty = 1; cycles(2);
        chk("R6", thr_irq, 1'b0, "irq held");

        // R1 hold-off of one bit, tick coinciding with stop pulse not counted
        tag = "R1";
        stop_done = 1; tick16 = 1; step(); stop_done = 0; tick16 = 0;
        shift_idle = 1; step();
        chk("R6", thr_irq, 1'b1, "irq after drain");
        ticks(15, 3);
        chk("R1", dir_out, 1'b0, "after 15 ticks");
        tick16 = 1; step(); tick16 = 0;
        chk("R1", dir_out, 1'b1, "after 16 ticks");
        cycles(3);

        // R4 cancel mid hold-off, then same-cycle write and last tick
        tag = "R4";
        fifo_empty = 0; shift_idle = 0; write_byte();
        fifo_empty = 1; stop_pulse();
        ticks(8, 2);
        write_byte();
        chk("R4", dir_out, 1'b0, "cancel mid");
        stop_pulse();
        ticks(15, 2);
        fifo_wr = 1; tick16 = 1; step(); fifo_wr = 0; tick16 = 0;
        chk("R4", dir_out, 1'b0, "write beats last tick");
        stop_pulse();
        ticks(15, 2);
        chk("R4", dir_out, 1'b0, "fresh count");
        ticks(1, 2);
        chk("R4", dir_out, 1'b1, "fresh count ends");

        // R5 inverted polarity
        tag = "R5";
        dir_inv = 1; step();
        chk("R5", dir_out, 1'b0, "inv rx");
        write_byte();
        chk("R5", dir_out, 1'b1, "inv tx");
        stop_pulse(); ticks(16, 2);
        chk("R5", dir_out, 1'b0, "inv rx again");
        dir_inv = 0;

        // R7 legacy interrupt, R8 manual pin
        tag = "R7";
        auto_en = 0; fifo_empty = 1; shift_idle = 0; cycles(2);
        chk("R7", thr_irq, 1'b1, "legacy irq");
        tag = "R8";
        mcr_rts = 1; step(); chk("R8", dir_out, 1'b1, "rts 1");
        mcr_rts = 0; step(); chk("R8", dir_out, 1'b0, "rts 0");
        write_byte(); stop_pulse(); ticks(4, 2);
        auto_en = 1; step();
        chk("R8", dir_out, 1'b1, "re-enable in rx");

        // mixed pseudo-random traffic judged by the model (R1)
        tag = "R1";
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                fifo_wr = (lf[7:3] == 5'd0);
                fifo_empty = lf[1] | lf[9];
                shift_idle = lf[2];
                stop_done = (lf[6:4] == 3'd5);
                tick16 = lf[8] & lf[11];
                auto_en = (lf[15:12] != 4'd0);
                dir_inv = lf[14] & lf[0] & lf[5];
                mcr_rts = lf[3];
                step();
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule